// File: doc/BRIEF.md
# DRAM refresh interval timer

This block paces DRAM refresh for a memory controller. Software programs a 16-bit compare value and a clock-select code. A 16-bit up-counter then advances on a prescaled tick taken from the system clock. When the counter reaches the compare value, the block does three things: it raises a sticky match flag, it can drive an interrupt, and it sends a one-cycle refresh request to the memory controller. On the tick after the match the counter returns to zero, so the requests repeat at a fixed interval of (compare + 1) × divider system clocks.

The block has three registers on a small synchronous bus: a control/status register, the counter and the compare register. A level output tells the memory controller to keep the DRAM in self-refresh. The selected tick is a one-cycle enable from a free-running prescaler, so the whole block runs in one clock domain.

Top module: `rfsh_interval_timer`

## Requirements
- R1: After reset all three registers read 0x0000, and `refresh_req`, `self_refresh` and `irq` are 0.
- R2: The registers sit at these word addresses: control/status at 0, counter at 1, compare at 2. Control bits 15 to 7 always read 0 and writes to them are dropped. The control bits are: bit 6 match flag, bit 5 interrupt enable, bits 4:2 clock select, bit 1 refresh enable, bit 0 refresh mode.
- R3: After reset the counter and the compare register both hold 0, and that equality never sets the flag. This stays true until the counter or the compare register is written or the counter increments.
- R4: Clock-select code 000 holds the counter at its value.
- R5: Only a match sets the match flag. Writing 1 to bit 6 never sets it and never clears it.
- R6: Clock-select codes 001 to 111 advance the counter once every 2, 8, 32, 128, 512, 2048 and 4096 system clocks. Successive matches are therefore (compare + 1) × divider clocks apart.
- R7: When bit 1 = 1 and bit 0 = 0, each match produces a `refresh_req` pulse exactly one cycle long. When bit 1 = 0, no pulse is produced, but the flag is still set.
- R8: The match flag clears only when two steps happen in order: the control register is first read while the flag is 1, and is then written with bit 6 = 0. A 0-write without such a read leaves the flag set. If a match occurs in the same cycle as a clear, the match wins.
- R9: `irq` is 1 exactly when the match flag and the interrupt enable are both 1.
- R10: `self_refresh` is 1 when bit 1 = 1 and bit 0 = 1. In that mode `refresh_req` stays 0.
- R11: A bus write to the counter takes effect at the next edge, even if a tick arrives in the same cycle. The written value reads back at once.
- R12: On the first tick after the counter equals the compare value, the counter reloads 0 instead of incrementing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of the control register with the flag set arms the clear |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| refresh_req | output | 1 | One-cycle refresh request per match |
| self_refresh | output | 1 | Level request to keep the DRAM in self-refresh |
| irq | output | 1 | Match interrupt |

## Verification
The one-cycle pulse property assumes that software never makes the counter equal the compare value with register writes on two consecutive cycles. The bench keeps every bus access one cycle long and leaves an idle cycle between accesses. The read-data properties assume the default combinational read path, and that `bus_wr` and `bus_rd` are never both high in the same cycle. Each bench step stops counting with code 000 before it reprograms the counter or the compare register, so no match can collide with the setup writes.

// File: rtl/rfsh_timer_pkg.sv
package rfsh_timer_pkg;
   localparam int CTRL_BITS = 7;
   localparam int ADR_CTRL  = 0;
   localparam int ADR_CNT   = 1;
   localparam int ADR_CMP   = 2;

   typedef struct packed {
      logic       flag;
      logic       ie;
      logic [2:0] sel;
      logic       ref_en;
      logic       self_mode;
   } ctrl_t;

   // log2 of the tick divider for each clock-select code; 0 means stopped
   function automatic int unsigned div_shift(input logic [2:0] sel);
      case (sel)
         3'd1:    return 1;
         3'd2:    return 3;
         3'd3:    return 5;
         3'd4:    return 7;
         3'd5:    return 9;
         3'd6:    return 11;
         3'd7:    return 12;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler
   import rfsh_timer_pkg::*;
#(
   parameter int PRE_W = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   output logic       tick
);
   generate
      if (PRE_W < 12) begin : g_bad_w
         $error("PRE_W must cover the largest divider of 4096");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   always_ff @(posedge clk) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + PRE_W'(1);
   end

   always_comb begin
      mask = (PRE_W'(1) << div_shift(sel)) - PRE_W'(1);
      tick = (sel != 3'd0) && ((pre_q & mask) == mask);
   end
endmodule

// File: rtl/rfsh_count_cmp.sv
module rfsh_count_cmp #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_cnt,
   input  logic             wr_cmp,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cmp,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q, cmp_d;
   logic             fresh_q, hit_q, wrap, load;

   always_comb begin
      wrap  = (cnt_q == cmp_q) && !fresh_q;
      load  = wr_cnt || wr_cmp || tick;
      cnt_d = cnt_q;
      if (wr_cnt)    cnt_d = wdata;
      else if (tick) cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
      cmp_d = wr_cmp ? wdata : cmp_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         cmp_q   <= '0;
         fresh_q <= 1'b1;
         hit_q   <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         cmp_q <= cmp_d;
         if (load) fresh_q <= 1'b0;
         hit_q <= load && (cnt_d == cmp_d);
      end
   end

   assign cnt = cnt_q;
   assign cmp = cmp_q;
   assign hit = hit_q;
endmodule

// File: rtl/rfsh_ctrl_reg.sv
module rfsh_ctrl_reg
   import rfsh_timer_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_ctrl,
   input  logic                 rd_ctrl,
   input  logic [CTRL_BITS-1:0] wdata,
   input  logic                 hit,
   output ctrl_t                ctrl
);
   ctrl_t ctrl_q;
   logic  armed_q, clr_try;

   assign clr_try = wr_ctrl && !wdata[6] && armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.ie        <= wdata[5];
            ctrl_q.sel       <= wdata[4:2];
            ctrl_q.ref_en    <= wdata[1];
            ctrl_q.self_mode <= wdata[0];
         end
         if (hit)          ctrl_q.flag <= 1'b1;
         else if (clr_try) ctrl_q.flag <= 1'b0;
         if (clr_try)                 armed_q <= 1'b0;
         else if (rd_ctrl && ctrl_q.flag) armed_q <= 1'b1;
      end
   end

   assign ctrl = ctrl_q;
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
   import rfsh_timer_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 2,
   parameter int PRE_W    = 12,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              refresh_req,
   output logic              self_refresh,
   output logic              irq
);
   generate
      if (DATA_W < CTRL_BITS) begin : g_bad_data
         $error("DATA_W must hold the control bits");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must decode three registers");
      end
   endgenerate

   logic              sel_ctrl, sel_cnt, sel_cmp, tick, hit;
   logic [DATA_W-1:0] cnt, cmp, rd_mux;
   ctrl_t             ctrl_s;

   assign sel_ctrl = (bus_addr == ADDR_W'(ADR_CTRL));
   assign sel_cnt  = (bus_addr == ADDR_W'(ADR_CNT));
   assign sel_cmp  = (bus_addr == ADDR_W'(ADR_CMP));

   rfsh_prescaler #(.PRE_W(PRE_W)) pre_i (
      .clk(clk), .rst_n(rst_n), .sel(ctrl_s.sel), .tick(tick)
   );

   rfsh_count_cmp #(.CNT_W(DATA_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .wr_cnt(bus_wr && sel_cnt), .wr_cmp(bus_wr && sel_cmp),
      .wdata(bus_wdata), .cnt(cnt), .cmp(cmp), .hit(hit)
   );

   rfsh_ctrl_reg ctl_i (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(bus_wr && sel_ctrl), .rd_ctrl(bus_rd && sel_ctrl),
      .wdata(bus_wdata[CTRL_BITS-1:0]), .hit(hit), .ctrl(ctrl_s)
   );

   always_comb begin
      rd_mux = '0;
      if (sel_ctrl)     rd_mux = DATA_W'(ctrl_s);
      else if (sel_cnt) rd_mux = cnt;
      else if (sel_cmp) rd_mux = cmp;
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      rd_q <= '0;
            else if (bus_rd) rd_q <= rd_mux;
         end
         assign bus_rdata = rd_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate

   assign refresh_req  = hit && ctrl_s.ref_en && !ctrl_s.self_mode;
   assign self_refresh = ctrl_s.ref_en && ctrl_s.self_mode;
   assign irq          = ctrl_s.flag && ctrl_s.ie;
endmodule

// File: rtl/rfsh_interval_timer_chk.sv
module rfsh_interval_timer_chk
   import rfsh_timer_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 2,
   parameter bit READ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              refresh_req,
   input logic              self_refresh,
   input logic              irq,
   input logic              flag,
   input logic              ie,
   input logic [2:0]        sel,
   input logic [DATA_W-1:0] cnt,
   input logic              hit
);
   logic w_ctrl, w_cnt;
   assign w_ctrl = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
   assign w_cnt  = bus_wr && (bus_addr == ADDR_W'(ADR_CNT));

   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!READ_REG && bus_addr == ADDR_W'(ADR_CTRL)) |-> (bus_rdata[DATA_W-1:CTRL_BITS] == '0));

   p_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 3'd0 && !w_cnt) |=> $stable(cnt));

   p_set_by_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(hit));

   p_req_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |=> !refresh_req);

   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(w_ctrl && !bus_wdata[6])) |=> flag);

   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && ie));

   p_self_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      self_refresh |-> !refresh_req);

   p_cnt_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      w_cnt |=> (cnt == $past(bus_wdata)));
endmodule

bind rfsh_interval_timer rfsh_interval_timer_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .READ_REG(READ_REG)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .refresh_req(refresh_req),
   .self_refresh(self_refresh), .irq(irq), .flag(ctrl_s.flag), .ie(ctrl_s.ie),
   .sel(ctrl_s.sel), .cnt(cnt), .hit(hit)
);

// File: tb/rfsh_interval_timer_tb_top.sv
`timescale 1ns/1ps
module rfsh_interval_timer_tb_top;
   localparam int DW = 16;
   localparam int AW = 2;
   localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_CMP = 2'd2;

   // {clock select, compare, expected interval in clocks}
   localparam logic [31:0] VEC [7] = '{
      {8'd1, 8'd3, 16'd8},    {8'd2, 8'd2, 16'd24},
      {8'd3, 8'd1, 16'd64},   {8'd4, 8'd0, 16'd128},
      {8'd5, 8'd1, 16'd1024}, {8'd6, 8'd0, 16'd2048},
      {8'd7, 8'd1, 16'd8192}
   };

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr = 1'b0, rd = 1'b0;
   logic [DW-1:0] wdata = '0, rdata;
   logic          refresh_req, self_refresh, irq;
   int            checks = 0, errors = 0;
   bit            done = 1'b0;

   always #4 clk = ~clk;

   rfsh_interval_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdata), .refresh_req(refresh_req),
      .self_refresh(self_refresh), .irq(irq)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk); addr = a; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic count_req(input int cycles, output int n);
      n = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (refresh_req) n++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [DW-1:0] v;
      int n, gap;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(A_CTRL, v); chk("R1 ctrl reset", v, 0);
      bus_read(A_CNT, v);  chk("R1 counter reset", v, 0);
      bus_read(A_CMP, v);  chk("R1 compare reset", v, 0);
      chk("R1 outputs reset", {refresh_req, self_refresh, irq}, 0);

      // R3 pristine equality must not set the flag
      bus_write(A_CTRL, 16'h0020);
      repeat (40) @(negedge clk);
      chk("R3 irq while pristine stopped", irq, 0);
      bus_read(A_CTRL, v); chk("R3 flag clear while stopped", v, 16'h0020);
      bus_write(A_CTRL, 16'h0024);
      repeat (40) @(negedge clk);
      chk("R3 irq after first ticks", irq, 0);
      bus_read(A_CTRL, v); chk("R3 flag clear after counting", v, 16'h0024);
      bus_read(A_CNT, v);  chk("R6 counter advanced", v != 0, 1);
      bus_write(A_CTRL, 16'h0000);

      // R2 reserved bits, R5 writing 1 to the flag does not set it
      bus_write(A_CTRL, 16'hFFC0);
      bus_read(A_CTRL, v); chk("R2 R5 reserved and flag write", v, 16'h0000);

      // R11 write readback, R4 code 000 holds the counter
      bus_write(A_CNT, 16'h1234);
      bus_read(A_CNT, v); chk("R11 counter write readback", v, 16'h1234);
      repeat (100) @(negedge clk);
      bus_read(A_CNT, v); chk("R4 counter held", v, 16'h1234);

      // R6 R7 R12 interval table
      for (int i = 0; i < 7; i++) begin
         bus_write(A_CTRL, 16'h0000);
         bus_write(A_CMP, DW'(VEC[i][23:16]));
         bus_write(A_CNT, 16'h0000);
         bus_write(A_CTRL, DW'({VEC[i][31:24], 2'b10}));
         seen = 1'b0;
         for (int k = 0; k < 2 * int'(VEC[i][15:0]) + 64 && !seen; k++) begin
            @(negedge clk);
            if (refresh_req) seen = 1'b1;
         end
         chk("R7 first pulse seen", seen, 1);
         @(negedge clk);
         chk("R7 pulse one cycle", refresh_req, 0);
         gap = 1; seen = 1'b0;
         for (int k = 0; k < int'(VEC[i][15:0]) + 64 && !seen; k++) begin
            @(negedge clk); gap++;
            if (refresh_req) seen = 1'b1;
         end
         chk("R6 R12 interval", gap, VEC[i][15:0]);
      end
      bus_write(A_CTRL, 16'h0000);

      // R8 R9 flag clear protocol and interrupt gating
      bus_write(A_CMP, 16'h0003);
      bus_write(A_CNT, 16'h0000);
      bus_write(A_CTRL, 16'h0024);
      seen = 1'b0;
      for (int k = 0; k < 100 && !seen; k++) begin
         @(negedge clk);
         if (irq) seen = 1'b1;
      end
      chk("R9 irq on match", seen, 1);
      bus_write(A_CTRL, 16'h0020);
      bus_read(A_CTRL, v); chk("R8 zero write without read ignored", v, 16'h0060);
      bus_write(A_CTRL, 16'h0040);
      chk("R9 irq masked", irq, 0);
      bus_read(A_CTRL, v); chk("R5 writing one keeps flag", v, 16'h0040);
      bus_write(A_CTRL, 16'h0060);
      chk("R9 irq unmasked", irq, 1);
      bus_write(A_CTRL, 16'h0020);
      bus_read(A_CTRL, v); chk("R8 flag cleared after read", v, 16'h0020);
      chk("R8 irq after clear", irq, 0);

      // R7 refresh disabled: flag sets, no pulses
      bus_write(A_CTRL, 16'h0000);
      bus_write(A_CNT, 16'h0000);
      bus_write(A_CTRL, 16'h0004);
      count_req(100, n);
      chk("R7 no pulse when disabled", n, 0);
      bus_read(A_CTRL, v); chk("R7 flag set when disabled", v, 16'h0044);

      // R10 self-refresh level
      bus_write(A_CTRL, 16'h0007);
      chk("R10 self refresh on", self_refresh, 1);
      count_req(100, n);
      chk("R10 no pulse in self refresh", n, 0);
      bus_write(A_CTRL, 16'h0005);
      chk("R10 self refresh needs enable", self_refresh, 0);

      finish_run();
   end
endmodule